// File: doc/BRIEF.md
# Configurable Interface Parity Checker

This block watches a parallel data interface and confirms that each transferred word arrived intact. The interface can run at 4, 8, 16 or 32 active data lines. Each word comes with up to two parity lines. The word is presented once per clock with a valid strobe. In single-rate operation only the rising-edge sample is used. In double-rate operation the capture logic in front of this block delivers both the rising-edge and falling-edge samples of the 16-line bus together, each with its own parity line.

Three checking modes are available: even parity, odd parity, and a marker mode. In marker mode the parity lines carry a fixed pattern that identifies the in-phase/quadrature phase rather than a parity value. A fourth mode code turns checking off. A word with any mismatch increments a saturating 8-bit error counter exactly once. If enabled, the mismatch also raises a sticky interrupt. Writing a one to the status location clears both the counter and the pending interrupt. Software reaches the counter, the enable and the status through a small register port. A register write takes effect at the clock edge where `reg_wr` is high, and reads are combinational.

The interrupt is tracked by a two-state machine. **ST_QUIET** is the reset state, with no interrupt pending. Transition *raise* leads from ST_QUIET to **ST_PEND**. It fires when a checked word is bad, the interrupt enable is set, and no clear is written in the same cycle. Transition *ack* leads from ST_PEND back to ST_QUIET when a clear is written. Every other case holds the current state.

Top module: `ipc_parity_chk`

## Requirements
- R1: In single-rate mode with `cfg_width` 0, 1 or 2 (4, 8 or 16 lines), `par_rise[0]` covers `dat_rise[3:0]`, `dat_rise[7:0]` or `dat_rise[15:0]` respectively. Data lines above the active width and `par_rise[1]` have no effect.
- R2: In single-rate mode with `cfg_width` 3 (32 lines), `par_rise[0]` covers `dat_rise[15:0]` and `par_rise[1]` covers `dat_rise[31:16]`. A mismatch on either lane marks the word bad.
- R3: When `cfg_ddr` is 1, `par_rise[0]` covers `dat_rise[15:0]` and `par_fall` covers `dat_fall`. `cfg_width`, `par_rise[1]` and `dat_rise[31:16]` are then ignored.
- R4: With `cfg_mode` 0 (even), a lane is bad when the XOR of its data bits and its parity bit is 1. With `cfg_mode` 1 (odd), a lane is bad when that XOR is 0.
- R5: With `cfg_mode` 2 (marker), a single-rate word is good only when `par_rise` equals 2'b01. A double-rate word is good only when `par_rise[0]` is 0 and `par_fall` is 1. Data is ignored in this mode.
- R6: With `cfg_mode` 3, no word is ever counted as bad.
- R7: Each bad word with `word_vld` high raises the counter by exactly one, even when both lanes fail. The counter holds at 255 instead of wrapping.
- R8: Writing `reg_wbit` = 1 to address 2 sets the counter to zero and drops the pending interrupt. This wins over a bad word in the same cycle. Writing 0 there has no effect.
- R9: A bad word while the enable (address 1, bit 0) is set makes `irq` high from the next cycle on. `irq` stays high until a clear, even if the enable is dropped. A bad word while the enable is 0 leaves `irq` low.
- R10: `reg_rdata` returns the counter at address 0, the enable in bit 0 at address 1, the pending flag in bit 0 at address 2, and zero at address 3.
- R11: After reset the counter, the enable and the pending flag are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_width | input | 2 | Active lines: 0=4, 1=8, 2=16, 3=32 |
| cfg_ddr | input | 1 | 1 selects double-rate checking |
| cfg_mode | input | 2 | 0 even, 1 odd, 2 marker, 3 off |
| word_vld | input | 1 | Word present this cycle |
| dat_rise | input | 32 | Rising-edge data sample |
| dat_fall | input | 16 | Falling-edge data sample |
| par_rise | input | 2 | Rising-edge parity lines |
| par_fall | input | 1 | Falling-edge parity line |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register address |
| reg_wbit | input | 1 | Register write data bit |
| reg_rdata | output | 8 | Register read data |
| irq | output | 1 | Parity interrupt pending |

## Verification
The assertions assume that the configuration inputs are stable while words flow, and that the clear condition is derived only from the register port. The stimulus therefore changes `cfg_width`, `cfg_ddr` and `cfg_mode` only on a negative edge in a cycle with no valid word. Register writes and words are applied through one task that holds every input for a full cycle. This keeps each increment, clear and enable change tied to one known edge, so the scoreboard can predict the counter and interrupt after every cycle.

// File: rtl/ipc_pkg.sv
package ipc_pkg;

    typedef enum logic [1:0] {
        BW_4  = 2'd0,
        BW_8  = 2'd1,
        BW_16 = 2'd2,
        BW_32 = 2'd3
    } bus_w_e;

    typedef enum logic [1:0] {
        CK_EVEN = 2'd0,
        CK_ODD  = 2'd1,
        CK_IQ   = 2'd2,
        CK_OFF  = 2'd3
    } chk_mode_e;

    typedef enum logic {
        ST_QUIET = 1'b0,
        ST_PEND  = 1'b1
    } irq_st_e;

    localparam logic [1:0] ADDR_CNT  = 2'd0;
    localparam logic [1:0] ADDR_CTRL = 2'd1;
    localparam logic [1:0] ADDR_STAT = 2'd2;

endpackage

// File: rtl/ipc_lane_eval.sv
module ipc_lane_eval
    import ipc_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic [1:0]          cfg_width,
    input  logic                cfg_ddr,
    input  logic [1:0]          cfg_mode,
    input  logic                word_vld,
    input  logic [DATA_W-1:0]   dat_rise,
    input  logic [DATA_W/2-1:0] dat_fall,
    input  logic [1:0]          par_rise,
    input  logic                par_fall,
    output logic                word_bad
);
    localparam int HALF = DATA_W / 2;
    localparam int QW   = DATA_W / 8;
    localparam int EW   = DATA_W / 4;
    localparam logic [HALF-1:0] MSK_Q = {{(HALF-QW){1'b0}}, {QW{1'b1}}};
    localparam logic [HALF-1:0] MSK_E = {{(HALF-EW){1'b0}}, {EW{1'b1}}};
    localparam logic [HALF-1:0] MSK_H = {HALF{1'b1}};

    function automatic logic lane_bad(input logic [HALF-1:0] d,
                                      input logic p, input logic odd);
        return (^d) ^ p ^ odd;
    endfunction

    logic [HALF-1:0] lo_mask;
    logic            odd_sel;
    logic            bad;

    always_comb begin
        unique case (bus_w_e'(cfg_width))
            BW_4:    lo_mask = MSK_Q;
            BW_8:    lo_mask = MSK_E;
            default: lo_mask = MSK_H;
        endcase
    end

    assign odd_sel = (chk_mode_e'(cfg_mode) == CK_ODD);

    always_comb begin
        bad = 1'b0;
        unique case (chk_mode_e'(cfg_mode))
            CK_EVEN, CK_ODD: begin
                if (cfg_ddr) begin
                    bad = lane_bad(dat_rise[HALF-1:0], par_rise[0], odd_sel)
                        | lane_bad(dat_fall, par_fall, odd_sel);
                end else begin
                    bad = lane_bad(dat_rise[HALF-1:0] & lo_mask, par_rise[0], odd_sel)
                        | ((bus_w_e'(cfg_width) == BW_32)
                           & lane_bad(dat_rise[DATA_W-1:HALF], par_rise[1], odd_sel));
                end
            end
            CK_IQ: begin
                if (cfg_ddr) bad = par_rise[0] | ~par_fall;
                else         bad = (par_rise != 2'b01);
            end
            default: bad = 1'b0;
        endcase
    end

    assign word_bad = word_vld & bad;

endmodule

// File: rtl/ipc_err_counter.sv
module ipc_err_counter #(
    parameter int CNT_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             inc,
    input  logic             clr,
    output logic [CNT_W-1:0] cnt
);
    localparam logic [CNT_W-1:0] CNT_MAX = {CNT_W{1'b1}};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                    cnt <= '0;
        else if (clr)                  cnt <= '0;
        else if (inc && cnt != CNT_MAX) cnt <= cnt + 1'b1;
    end

endmodule

// File: rtl/ipc_irq_fsm.sv
module ipc_irq_fsm
    import ipc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic err,
    input  logic en,
    input  logic clr,
    output logic pend
);
    irq_st_e st_q, st_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_QUIET;
        else        st_q <= st_d;
    end

    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_QUIET: if (err && en && !clr) st_d = ST_PEND;
            ST_PEND:  if (clr)               st_d = ST_QUIET;
            default:  st_d = ST_QUIET;
        endcase
    end

    always_comb begin
        pend = (st_q == ST_PEND);
    end

endmodule

// File: rtl/ipc_parity_chk.sv
module ipc_parity_chk
    import ipc_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int CNT_W  = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          cfg_width,
    input  logic                cfg_ddr,
    input  logic [1:0]          cfg_mode,
    input  logic                word_vld,
    input  logic [DATA_W-1:0]   dat_rise,
    input  logic [DATA_W/2-1:0] dat_fall,
    input  logic [1:0]          par_rise,
    input  logic                par_fall,
    input  logic                reg_wr,
    input  logic [1:0]          reg_addr,
    input  logic                reg_wbit,
    output logic [CNT_W-1:0]    reg_rdata,
    output logic                irq
);
    logic             word_bad;
    logic             clr_hit;
    logic             irq_en_q;
    logic [CNT_W-1:0] err_cnt;
    logic             pend;

    assign clr_hit = reg_wr && (reg_addr == ADDR_STAT) && reg_wbit;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                irq_en_q <= 1'b0;
        else if (reg_wr && reg_addr == ADDR_CTRL)  irq_en_q <= reg_wbit;
    end

    ipc_lane_eval #(.DATA_W(DATA_W)) u_eval (
        .cfg_width (cfg_width),
        .cfg_ddr   (cfg_ddr),
        .cfg_mode  (cfg_mode),
        .word_vld  (word_vld),
        .dat_rise  (dat_rise),
        .dat_fall  (dat_fall),
        .par_rise  (par_rise),
        .par_fall  (par_fall),
        .word_bad  (word_bad)
    );

    ipc_err_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .inc   (word_bad),
        .clr   (clr_hit),
        .cnt   (err_cnt)
    );

    ipc_irq_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .err   (word_bad),
        .en    (irq_en_q),
        .clr   (clr_hit),
        .pend  (pend)
    );

    assign irq = pend;

    always_comb begin
        unique case (reg_addr)
            ADDR_CNT:  reg_rdata = err_cnt;
            ADDR_CTRL: reg_rdata = {{(CNT_W-1){1'b0}}, irq_en_q};
            ADDR_STAT: reg_rdata = {{(CNT_W-1){1'b0}}, pend};
            default:   reg_rdata = '0;
        endcase
    end

endmodule

// File: rtl/ipc_parity_chk_sva.sv
module ipc_parity_chk_sva #(
    parameter int CNT_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       cfg_mode,
    input logic             reg_wr,
    input logic [1:0]       reg_addr,
    input logic             reg_wbit,
    input logic [CNT_W-1:0] cnt,
    input logic             irq
);
    logic clr_w;
    assign clr_w = reg_wr && (reg_addr == 2'd2) && reg_wbit;

    // R7
    cnt_sat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == {CNT_W{1'b1}} && !clr_w) |=> (cnt == {CNT_W{1'b1}}));

    // R7
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !clr_w |=> (cnt == $past(cnt) || cnt == $past(cnt) + 1'b1));

    // R8
    clr_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        clr_w |=> (cnt == '0 && !irq));

    // R9
    irq_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq && !clr_w) |=> irq);

    // R6
    off_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_mode == 2'd3 && !clr_w) |=> $stable(cnt));

endmodule

bind ipc_parity_chk ipc_parity_chk_sva #(.CNT_W(CNT_W)) u_sva (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfg_mode (cfg_mode),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wbit (reg_wbit),
    .cnt      (err_cnt),
    .irq      (irq)
);

// File: tb/tb_ipc_parity_chk.sv
`timescale 1ns/1ps
module tb_ipc_parity_chk;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_width = 2'd0;
    logic        cfg_ddr = 1'b0;
    logic [1:0]  cfg_mode = 2'd0;
    logic        word_vld = 1'b0;
    logic [31:0] dat_rise = '0;
    logic [15:0] dat_fall = '0;
    logic [1:0]  par_rise = '0;
    logic        par_fall = 1'b0;
    logic        reg_wr = 1'b0;
    logic [1:0]  reg_addr = 2'd0;
    logic        reg_wbit = 1'b0;
    logic [7:0]  reg_rdata;
    logic        irq;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    logic [7:0] m_cnt = 0;
    logic       m_pend = 0;
    logic       m_en = 0;

    typedef struct {
        logic [7:0] cnt;
        logic       irq;
        logic       chk_cnt;
        string      tag;
    } exp_t;
    exp_t sb[$];

    always #5 clk = ~clk;

    ipc_parity_chk dut (
        .clk(clk), .rst_n(rst_n), .cfg_width(cfg_width), .cfg_ddr(cfg_ddr),
        .cfg_mode(cfg_mode), .word_vld(word_vld), .dat_rise(dat_rise),
        .dat_fall(dat_fall), .par_rise(par_rise), .par_fall(par_fall),
        .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wbit(reg_wbit),
        .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic cyc(input logic v, input logic [31:0] dr, input logic [15:0] df,
                       input logic [1:0] pr, input logic pf, input logic wr,
                       input logic [1:0] a, input logic wb, input logic bad,
                       input string tag);
        exp_t it;
        @(negedge clk);
        word_vld = v; dat_rise = dr; dat_fall = df; par_rise = pr; par_fall = pf;
        reg_wr = wr; reg_addr = a; reg_wbit = wb;
        if (wr && a == 2'd2 && wb) begin
            m_cnt = 0; m_pend = 0;
        end else if (v && bad) begin
            if (m_cnt != 8'hFF) m_cnt = m_cnt + 1;
            if (m_en) m_pend = 1;
        end
        if (wr && a == 2'd1) m_en = wb;
        it.cnt = m_cnt; it.irq = m_pend; it.chk_cnt = (a == 2'd0); it.tag = tag;
        sb.push_back(it);
    endtask

    task automatic word(input logic [31:0] dr, input logic [15:0] df,
                        input logic [1:0] pr, input logic pf, input logic bad,
                        input string tag);
        cyc(1'b1, dr, df, pr, pf, 1'b0, 2'd0, 1'b0, bad, tag);
    endtask

    task automatic wreg(input logic [1:0] a, input logic wb, input string tag);
        cyc(1'b0, '0, '0, 2'b00, 1'b0, 1'b1, a, wb, 1'b0, tag);
    endtask

    task automatic set_cfg(input logic [1:0] w, input logic d, input logic [1:0] m);
        @(negedge clk);
        word_vld = 0; reg_wr = 0; reg_addr = 2'd0;
        cfg_width = w; cfg_ddr = d; cfg_mode = m;
    endtask

    task automatic rd_chk(input logic [1:0] a, input logic [7:0] exp, input string tag);
        @(negedge clk);
        word_vld = 0; reg_wr = 0; reg_addr = a;
        #1;
        checks++;
        if (reg_rdata !== exp) begin
            errors++;
            $display("FAIL %s: rdata act=%0h exp=%0h", tag, reg_rdata, exp);
        end
    endtask

    always @(posedge clk) begin
        exp_t it;
        #2;
        if (sb.size() > 0) begin
            it = sb.pop_front();
            checks++;
            if (irq !== it.irq) begin
                errors++;
                $display("FAIL %s: irq act=%0b exp=%0b", it.tag, irq, it.irq);
            end
            if (it.chk_cnt) begin
                checks++;
                if (reg_rdata !== it.cnt) begin
                    errors++;
                    $display("FAIL %s: count act=%0d exp=%0d", it.tag, reg_rdata, it.cnt);
                end
            end
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: act=running exp=finished");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;

        // R11 reset values
        rd_chk(2'd0, 8'd0, "R11 count");
        rd_chk(2'd1, 8'd0, "R11 enable");
        rd_chk(2'd2, 8'd0, "R11 pending");
        checks++;
        if (irq !== 1'b0) begin errors++; $display("FAIL R11: irq act=%0b exp=0", irq); end

        // R1 R4 4-line even: upper lines and par_rise[1] ignored
        set_cfg(2'd0, 1'b0, 2'd0);
        word(32'hABCD_12F1, '0, 2'b11, 1'b0, 1'b0, "R1 w4 even good");
        word(32'hABCD_12F1, '0, 2'b10, 1'b0, 1'b1, "R1 w4 even bad");
        // R4 8-line odd
        set_cfg(2'd1, 1'b0, 2'd1);
        word(32'hFFFF_FF03, '0, 2'b01, 1'b0, 1'b0, "R4 w8 odd good");
        word(32'hFFFF_FF03, '0, 2'b00, 1'b0, 1'b1, "R4 w8 odd bad");
        // R1 16-line even
        set_cfg(2'd2, 1'b0, 2'd0);
        word(32'h5555_0007, '0, 2'b01, 1'b0, 1'b0, "R1 w16 upper ignored");
        word(32'h0000_0007, '0, 2'b10, 1'b0, 1'b1, "R1 w16 bad");
        // R2 R7 32-line split
        set_cfg(2'd3, 1'b0, 2'd0);
        word(32'h0001_0001, '0, 2'b11, 1'b0, 1'b0, "R2 w32 good");
        word(32'h0001_0001, '0, 2'b00, 1'b0, 1'b1, "R7 both lanes one step");
        word(32'h0001_0001, '0, 2'b01, 1'b0, 1'b1, "R2 upper lane bad");
        // R3 double-rate, width ignored
        set_cfg(2'd0, 1'b1, 2'd0);
        word(32'hFFFF_0010, 16'h0003, 2'b01, 1'b0, 1'b0, "R3 ddr good");
        word(32'hFFFF_0010, 16'h0003, 2'b01, 1'b1, 1'b1, "R3 ddr falling bad");
        // R5 marker single-rate and double-rate
        set_cfg(2'd3, 1'b0, 2'd2);
        word(32'h1234_5678, '0, 2'b01, 1'b0, 1'b0, "R5 sdr marker good");
        word(32'h1234_5678, '0, 2'b10, 1'b0, 1'b1, "R5 sdr marker bad");
        set_cfg(2'd3, 1'b1, 2'd2);
        word(32'h0, '0, 2'b10, 1'b1, 1'b0, "R5 ddr marker good");
        word(32'h0, '0, 2'b01, 1'b0, 1'b1, "R5 ddr marker bad");
        // R6 off mode
        set_cfg(2'd3, 1'b0, 2'd3);
        word(32'h0000_0001, '0, 2'b10, 1'b1, 1'b0, "R6 off no count");

        // R9 interrupt enable, sticky
        set_cfg(2'd0, 1'b0, 2'd0);
        wreg(2'd1, 1'b1, "R9 enable");
        rd_chk(2'd1, 8'd1, "R10 enable readback");
        word(32'h0, '0, 2'b01, 1'b0, 1'b1, "R9 raise");
        rd_chk(2'd2, 8'd1, "R10 pending readback");
        wreg(2'd1, 1'b0, "R9 disable keeps pending");
        word(32'h0, '0, 2'b00, 1'b0, 1'b0, "R9 still pending");
        wreg(2'd2, 1'b0, "R8 zero write no clear");
        word(32'h0, '0, 2'b00, 1'b0, 1'b0, "R8 unchanged");
        wreg(2'd2, 1'b1, "R8 clear");
        word(32'h0, '0, 2'b00, 1'b0, 1'b0, "R8 cleared");
        rd_chk(2'd3, 8'd0, "R10 addr3 zero");
        // R8 clear beats simultaneous error
        wreg(2'd1, 1'b1, "R9 re-enable");
        cyc(1'b1, 32'h0, '0, 2'b01, 1'b0, 1'b1, 2'd2, 1'b1, 1'b1, "R8 clear priority");
        word(32'h0, '0, 2'b00, 1'b0, 1'b0, "R8 after priority");
        // R9 disabled error does not raise
        wreg(2'd1, 1'b0, "R9 disable");
        word(32'h0, '0, 2'b01, 1'b0, 1'b1, "R9 no raise when disabled");
        // R7 saturation
        for (int i = 0; i < 260; i++)
            word(32'h0, '0, 2'b01, 1'b0, 1'b1, "R7 saturate");
        word(32'h0, '0, 2'b00, 1'b0, 1'b0, "R7 hold 255");
        wreg(2'd2, 1'b1, "R8 clear from max");
        word(32'h0, '0, 2'b00, 1'b0, 1'b0, "R8 zero after max");

        set_cfg(2'd0, 1'b0, 2'd0);
        repeat (4) @(posedge clk);
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule